// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block is the command front end of a parallel NOR flash, modelled on a synchronous bus. On each clock edge the bus can present a write strobe or a read strobe, together with an address and a data word. The sequencer follows the multi-cycle unlock patterns and the command bytes that come after them. It keeps track of which mode the device is in: array read, identification read, single-word program, buffered program, sector erase, erase suspend, and a sticky abort state.

Each accepted operation appears for one cycle as an operation record for a stub array model. The record carries the kind, address, data and buffer count. In identification mode, reads return the manufacturer code, the device code and a per-sector protection flag. In all other modes, reads pass the stub array's data through.

Program and erase timing is modelled only as a busy window of `BUSY_CYC` cycles. An erase can be paused and resumed, and the window keeps the cycles it had left when it was paused.

Top module: `pflash_cmd_seq`

## Requirements
- R1: After reset, `ctx_o`=0 (array read), `phase_o`=0 (idle), and `busy`, `erase_susp` and `op_valid` are all 0.
- R2: A write of AAh whose low 11 address bits are 555h sets `phase_o`=1. A following write of 55h at low address 2AAh sets `phase_o`=2. Any other write while `phase_o` is 1, 2, 7, 8 or 9 sets `phase_o`=0 and `ctx_o`=0, unless `ctx_o`=2. Only data bits 7:0 are compared.
- R3: An unlock followed by command 90h sets `ctx_o`=1 (identification). While `ctx_o`=1, a read returns the following, based on address bits 7:0: C2h at 00h, `DEV_ID` at 01h, and at 02h either 0001h if `prot_in` is high or 0000h if it is low. Outside identification mode, reads return `arr_data`. `rdata` holds the value from the clock edge of the read onward.
- R4: A single F0h write with `phase_o`=0 sets `ctx_o`=0 when `ctx_o` is 1. While `ctx_o`=2 (abort), a single F0h write has no effect.
- R5: An unlock followed by A0h sets `phase_o`=3. The next write issues `op_kind`=0 carrying that write's address and data, and `busy` then stays high for exactly `BUSY_CYC` cycles. While `busy` is high, writes other than suspend are ignored.
- R6: An unlock followed by 25h sets `phase_o`=4. The next write gives N-1 in its data. Each of the next N writes issues `op_kind`=1 with `op_count` equal to its index from 0. After the last of them, `phase_o`=6. A write of 29h then issues `op_kind`=2 with `op_addr` set to the first load address, `op_count`=N-1, and starts `busy`.
- R7: In the following cases `ctx_o` becomes 2: a count value of `BUF_WORDS` or more; a load address whose bits above log2(`BUF_WORDS`) differ from those of the first load; or any confirm byte other than 29h.
- R8: Only an unlock followed by F0h leaves `ctx_o`=2. Other unlock plus command sequences, for example 90h, leave the block in abort.
- R9: The sequence AA/55/80h, then AA/55/30h, issues `op_kind`=3. Its `op_addr` is the last write's address with the bits below `SECT_LSB` cleared, and the erase window then starts.
- R10: B0h written during a running erase sets `erase_susp`=1 and drops `busy`. B0h written at any other time changes nothing.
- R11: 30h written with `phase_o`=0 while suspended clears `erase_susp`. `busy` then stays high for the erase cycles that were left. 30h written when not suspended changes nothing.
- R12: While suspended, a program aimed at the sector being erased issues no operation, and a program to any other sector issues one. Identification mode can be entered while suspended. F0h then returns to `ctx_o`=0 with `erase_susp` still 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write cycle strobe |
| rd_en | input | 1 | Read cycle strobe |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data / command byte |
| prot_in | input | 1 | Protection flag of the addressed sector, from the array stub |
| arr_data | input | DATA_W | Array read data from the stub |
| rdata | output | DATA_W | Registered read data |
| op_valid | output | 1 | One-cycle operation record strobe |
| op_kind | output | 2 | 0 program, 1 buffer load, 2 buffer program, 3 sector erase |
| op_addr | output | ADDR_W | Operation address |
| op_data | output | DATA_W | Operation data |
| op_count | output | log2(BUF_WORDS) | Buffer index or count minus one |
| busy | output | 1 | Program or unsuspended erase in progress |
| erase_susp | output | 1 | Erase suspended |
| ctx_o | output | 2 | 0 read, 1 identification, 2 abort |
| phase_o | output | 4 | 0 idle, 1-2 unlock, 3 program data, 4 count, 5 loading, 6 confirm, 7-9 erase second unlock |

## Verification
Every result comes from a register. Mode, phase, suspend flag, operation record and read data all change at the clock edge that accepts the write or read, so they are due one cycle after the stimulus is presented. The bench drives on the falling edge and samples 1 ns after the next rising edge. `busy` rises at that same edge and is counted edge by edge until it falls. After a resume, the expected count is the window minus the erase cycles that ran before the suspend, which the bench works out from how far apart it issued the two writes.

// File: rtl/pflash_cmd_pkg.sv
package pflash_cmd_pkg;
  typedef enum logic [1:0] {CTX_READ = 2'd0, CTX_ASEL = 2'd1, CTX_ABORT = 2'd2} ctx_e;
  typedef enum logic [3:0] {
    PH_IDLE = 4'd0, PH_UNLK1 = 4'd1, PH_UNLK2 = 4'd2, PH_PROG = 4'd3,
    PH_WBCNT = 4'd4, PH_WBLOAD = 4'd5, PH_WBCONF = 4'd6,
    PH_ER1 = 4'd7, PH_ER2 = 4'd8, PH_ER3 = 4'd9
  } phase_e;
  typedef enum logic [1:0] {OP_PROG = 2'd0, OP_BUFLOAD = 2'd1, OP_BUFPROG = 2'd2, OP_ERASE = 2'd3} op_e;

  localparam logic [7:0] C_KEY1    = 8'hAA;
  localparam logic [7:0] C_KEY2    = 8'h55;
  localparam logic [7:0] C_IDENT   = 8'h90;
  localparam logic [7:0] C_PROG    = 8'hA0;
  localparam logic [7:0] C_BUF     = 8'h25;
  localparam logic [7:0] C_CONFIRM = 8'h29;
  localparam logic [7:0] C_ERSETUP = 8'h80;
  localparam logic [7:0] C_ERGO    = 8'h30;
  localparam logic [7:0] C_SUSP    = 8'hB0;
  localparam logic [7:0] C_RESET   = 8'hF0;
  localparam logic [10:0] A_KEY1   = 11'h555;
  localparam logic [10:0] A_KEY2   = 11'h2AA;
  localparam logic [7:0] MFR_CODE  = 8'hC2;
endpackage

// File: rtl/fcs_busy_timer.sv
module fcs_busy_timer #(
  parameter int LOAD = 8,
  localparam int W = $clog2(LOAD + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic hold,
  output logic active
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt <= '0;
    else if (start)             cnt <= W'(LOAD);
    else if (cnt != '0 && !hold) cnt <= cnt - 1'b1;
  end

  assign active = (cnt != '0);
endmodule

// File: rtl/fcs_id_mux.sv
module fcs_id_mux #(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 16,
  parameter logic [DATA_W-1:0] DEV_ID = 16'h22C9
) (
  input  logic              ident,
  input  logic [ADDR_W-1:0] addr,
  input  logic              prot,
  input  logic [DATA_W-1:0] arr_data,
  output logic [DATA_W-1:0] value
);
  import pflash_cmd_pkg::*;

  always_comb begin
    value = arr_data;
    if (ident) begin
      case (addr[7:0])
        8'h00:   value = DATA_W'(MFR_CODE);
        8'h01:   value = DEV_ID;
        8'h02:   value = DATA_W'(prot);
        default: value = '0;
      endcase
    end
  end
endmodule

// File: rtl/pflash_cmd_seq.sv
module pflash_cmd_seq #(
  parameter int ADDR_W   = 22,
  parameter int DATA_W   = 16,
  parameter int SECT_LSB = 12,
  parameter int BUF_WORDS = 16,
  parameter int BUSY_CYC = 8,
  parameter logic [DATA_W-1:0] DEV_ID = 16'h22C9
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic                          rd_en,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             wdata,
  input  logic                          prot_in,
  input  logic [DATA_W-1:0]             arr_data,
  output logic [DATA_W-1:0]             rdata,
  output logic                          op_valid,
  output logic [1:0]                    op_kind,
  output logic [ADDR_W-1:0]             op_addr,
  output logic [DATA_W-1:0]             op_data,
  output logic [$clog2(BUF_WORDS)-1:0]  op_count,
  output logic                          busy,
  output logic                          erase_susp,
  output logic [1:0]                    ctx_o,
  output logic [3:0]                    phase_o
);
  import pflash_cmd_pkg::*;

  localparam int PAGE_LSB = $clog2(BUF_WORDS);
  localparam int CNT_W    = $clog2(BUF_WORDS);

  function automatic logic [ADDR_W-1:0] sect_base(input logic [ADDR_W-1:0] a);
    return (a >> SECT_LSB) << SECT_LSB;
  endfunction
  function automatic logic same_page(input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] b);
    return (a >> PAGE_LSB) == (b >> PAGE_LSB);
  endfunction
  function automatic logic key_match(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                                     input logic [10:0] ka, input logic [7:0] kd);
    return (a[10:0] == ka) && (d[7:0] == kd);
  endfunction

  ctx_e   ctx, ctx_n;
  phase_e phase, ph_n;
  logic   susp, susp_n;
  logic [CNT_W-1:0]  wb_cnt, wb_cnt_n, wb_ld, wb_ld_n;
  logic [ADDR_W-1:0] wb_base, wb_base_n, er_sect, er_sect_n;
  logic [7:0] cmd;

  // named events for the checker
  logic ev_brk, ev_abort, ev_abort_clr, ev_op;
  logic prog_go, er_go, blocked, er_running;
  op_e  opk_n;
  logic [ADDR_W-1:0] opa_n;
  logic [DATA_W-1:0] opd_n;
  logic [CNT_W-1:0]  opc_n;

  logic [1:0] t_start, t_hold, t_active;
  assign t_start = {er_go, prog_go};
  assign t_hold  = {susp, 1'b0};

  for (genvar g = 0; g < 2; g++) begin : g_tmr
    fcs_busy_timer #(.LOAD(BUSY_CYC)) u_tmr (
      .clk(clk), .rst_n(rst_n), .start(t_start[g]), .hold(t_hold[g]), .active(t_active[g])
    );
  end

  assign er_running = t_active[1] & ~susp;
  assign blocked    = t_active[0] | er_running;
  assign cmd        = wdata[7:0];

  always_comb begin
    ctx_n = ctx; ph_n = phase; susp_n = susp;
    wb_cnt_n = wb_cnt; wb_ld_n = wb_ld; wb_base_n = wb_base; er_sect_n = er_sect;
    ev_brk = 1'b0; ev_abort = 1'b0; ev_abort_clr = 1'b0; ev_op = 1'b0;
    prog_go = 1'b0; er_go = 1'b0;
    opk_n = OP_PROG; opa_n = addr; opd_n = wdata; opc_n = '0;
    if (wr_en && er_running) begin
      if (cmd == C_SUSP) susp_n = 1'b1;
    end else if (wr_en && !blocked) begin
      case (phase)
        PH_IDLE: begin
          if (key_match(addr, wdata, A_KEY1, C_KEY1)) ph_n = PH_UNLK1;
          else if (cmd == C_RESET && ctx != CTX_ABORT) ctx_n = CTX_READ;
          else if (cmd == C_ERGO && susp) susp_n = 1'b0;
        end
        PH_UNLK1: if (key_match(addr, wdata, A_KEY2, C_KEY2)) ph_n = PH_UNLK2; else ev_brk = 1'b1;
        PH_UNLK2: begin
          ph_n = PH_IDLE;
          if (ctx == CTX_ABORT) begin
            if (cmd == C_RESET) begin ctx_n = CTX_READ; ev_abort_clr = 1'b1; end
            else ev_brk = 1'b1;
          end else begin
            case (cmd)
              C_IDENT:   ctx_n = CTX_ASEL;
              C_PROG:    ph_n = PH_PROG;
              C_BUF:     ph_n = PH_WBCNT;
              C_ERSETUP: if (!susp) ph_n = PH_ER1; else ev_brk = 1'b1;
              C_RESET:   ctx_n = CTX_READ;
              default:   ev_brk = 1'b1;
            endcase
          end
        end
        PH_PROG: begin
          ph_n = PH_IDLE; ctx_n = CTX_READ;
          if (!(susp && sect_base(addr) == er_sect)) begin ev_op = 1'b1; prog_go = 1'b1; end
        end
        PH_WBCNT: begin
          if (wdata >= DATA_W'(BUF_WORDS)) ev_abort = 1'b1;
          else begin wb_cnt_n = wdata[CNT_W-1:0]; wb_ld_n = '0; ph_n = PH_WBLOAD; end
        end
        PH_WBLOAD: begin
          if (wb_ld != '0 && !same_page(addr, wb_base)) ev_abort = 1'b1;
          else begin
            if (wb_ld == '0) wb_base_n = addr;
            ev_op = 1'b1; opk_n = OP_BUFLOAD; opc_n = wb_ld;
            wb_ld_n = wb_ld + 1'b1;
            if (wb_ld == wb_cnt) ph_n = PH_WBCONF;
          end
        end
        PH_WBCONF: begin
          if (cmd == C_CONFIRM) begin
            ev_op = 1'b1; opk_n = OP_BUFPROG; opa_n = wb_base; opc_n = wb_cnt;
            prog_go = 1'b1; ph_n = PH_IDLE; ctx_n = CTX_READ;
          end else ev_abort = 1'b1;
        end
        PH_ER1: if (key_match(addr, wdata, A_KEY1, C_KEY1)) ph_n = PH_ER2; else ev_brk = 1'b1;
        PH_ER2: if (key_match(addr, wdata, A_KEY2, C_KEY2)) ph_n = PH_ER3; else ev_brk = 1'b1;
        PH_ER3: begin
          if (cmd == C_ERGO) begin
            ev_op = 1'b1; opk_n = OP_ERASE; opa_n = sect_base(addr);
            er_go = 1'b1; er_sect_n = sect_base(addr); ph_n = PH_IDLE; ctx_n = CTX_READ;
          end else ev_brk = 1'b1;
        end
        default: ev_brk = 1'b1;
      endcase
      if (ev_brk) begin
        ph_n = PH_IDLE;
        if (ctx != CTX_ABORT) ctx_n = CTX_READ;
      end
      if (ev_abort) begin ph_n = PH_IDLE; ctx_n = CTX_ABORT; end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctx <= CTX_READ; phase <= PH_IDLE; susp <= 1'b0;
      wb_cnt <= '0; wb_ld <= '0; wb_base <= '0; er_sect <= '0;
      op_valid <= 1'b0; op_kind <= '0; op_addr <= '0; op_data <= '0; op_count <= '0;
    end else begin
      ctx <= ctx_n; phase <= ph_n; susp <= susp_n;
      wb_cnt <= wb_cnt_n; wb_ld <= wb_ld_n; wb_base <= wb_base_n; er_sect <= er_sect_n;
      op_valid <= ev_op;
      if (ev_op) begin
        op_kind <= opk_n; op_addr <= opa_n; op_data <= opd_n; op_count <= opc_n;
      end
    end
  end

  logic [DATA_W-1:0] rd_val;
  fcs_id_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEV_ID(DEV_ID)) u_id (
    .ident(ctx == CTX_ASEL), .addr(addr), .prot(prot_in), .arr_data(arr_data), .value(rd_val)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_val;
  end

  assign busy       = t_active[0] | er_running;
  assign erase_susp = susp;
  assign ctx_o      = ctx;
  assign phase_o    = phase;
endmodule

// File: rtl/pflash_cmd_seq_chk.sv
module pflash_cmd_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] ctx,
  input logic [3:0] phase,
  input logic       susp,
  input logic       busy,
  input logic       op_valid,
  input logic [1:0] op_kind,
  input logic       ev_brk,
  input logic       ev_abort_clr
);
  a_r2_break_to_read: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_brk && ctx != 2'd2) |=> (ctx == 2'd0 && phase == 4'd0));

  a_r3_ident_after_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctx == 2'd1) |-> $past(phase) == 4'd2);

  a_r5_prog_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_kind == 2'd0 || op_kind == 2'd2)) |-> busy);

  a_r6_confirm_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 4'd6) |-> ($past(phase) == 4'd5 || $past(phase) == 4'd6));

  a_r8_abort_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx == 2'd2 && !ev_abort_clr) |=> ctx == 2'd2);

  a_r10_suspend_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(susp) |-> !busy);

  a_r11_resume_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(susp) |-> busy);
endmodule

bind pflash_cmd_seq pflash_cmd_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctx(ctx), .phase(phase), .susp(susp), .busy(busy),
  .op_valid(op_valid), .op_kind(op_kind), .ev_brk(ev_brk), .ev_abort_clr(ev_abort_clr)
);

// File: tb/tb_pflash_cmd_seq.sv
module tb_pflash_cmd_seq;
  localparam int AW = 22, DW = 16, BUSY = 8;
  localparam logic [15:0] DEVID = 16'h22C9;
  localparam logic [15:0] ARR = 16'h5A5A;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0, prot_in = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, arr_data = ARR, rdata, op_data;
  logic op_valid, busy, erase_susp;
  logic [1:0] op_kind, ctx_o;
  logic [AW-1:0] op_addr;
  logic [3:0] op_count, phase_o;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  pflash_cmd_seq #(.BUSY_CYC(BUSY), .DEV_ID(DEVID)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .prot_in(prot_in), .arr_data(arr_data), .rdata(rdata), .op_valid(op_valid),
    .op_kind(op_kind), .op_addr(op_addr), .op_data(op_data), .op_count(op_count),
    .busy(busy), .erase_susp(erase_susp), .ctx_o(ctx_o), .phase_o(phase_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1 wr_en = 1'b0;
  endtask
  task automatic rd(input logic [AW-1:0] a);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(posedge clk); #1 rd_en = 1'b0;
  endtask
  task automatic unlock(input logic [7:0] c, input logic [AW-1:0] a);
    wr(22'h555, 16'h00AA); wr(22'h2AA, 16'h0055); wr(a, {8'h00, c});
  endtask
  task automatic wait_idle();
    while (busy) @(posedge clk);
    #1;
  endtask
  task automatic count_busy(output int n);
    n = 0;
    while (busy) begin n++; @(posedge clk); #1; end
  endtask

  // {rd, addr, data(write data or expected read data), ctx, phase}
  localparam int NV = 24;
  localparam logic [44:0] VEC [NV] = '{
    {1'b0, 22'h000555, 16'h00AA, 2'd0, 4'd1},  // R2
    {1'b0, 22'h0002AA, 16'h0055, 2'd0, 4'd2},  // R2
    {1'b0, 22'h000123, 16'h0090, 2'd1, 4'd0},  // R3
    {1'b1, 22'h000000, 16'h00C2, 2'd1, 4'd0},  // R3
    {1'b1, 22'h000001, DEVID,    2'd1, 4'd0},  // R3
    {1'b1, 22'h003002, 16'h0001, 2'd1, 4'd0},  // R3
    {1'b0, 22'h000000, 16'h00F0, 2'd0, 4'd0},  // R4
    {1'b1, 22'h000040, ARR,      2'd0, 4'd0},  // R3
    {1'b0, 22'h3FF555, 16'h00AA, 2'd0, 4'd1},  // R2 high bits ignored
    {1'b0, 22'h0002AA, 16'h0012, 2'd0, 4'd0},  // R2 break
    {1'b0, 22'h000555, 16'h00AA, 2'd0, 4'd1},
    {1'b0, 22'h0002AA, 16'h0055, 2'd0, 4'd2},
    {1'b0, 22'h000000, 16'h0077, 2'd0, 4'd0},  // R2 break on bad command
    {1'b0, 22'h000555, 16'h00AA, 2'd0, 4'd1},
    {1'b0, 22'h0002AA, 16'h0055, 2'd0, 4'd2},
    {1'b0, 22'h002000, 16'h0025, 2'd0, 4'd4},  // R6
    {1'b0, 22'h002000, 16'h0010, 2'd2, 4'd0},  // R7 count too big
    {1'b0, 22'h000000, 16'h00F0, 2'd2, 4'd0},  // R4 no effect in abort
    {1'b0, 22'h000555, 16'h00AA, 2'd2, 4'd1},
    {1'b0, 22'h0002AA, 16'h0055, 2'd2, 4'd2},
    {1'b0, 22'h000000, 16'h0090, 2'd2, 4'd0},  // R8 stays abort
    {1'b0, 22'h000555, 16'h00AA, 2'd2, 4'd1},
    {1'b0, 22'h0002AA, 16'h0055, 2'd2, 4'd2},
    {1'b0, 22'h000000, 16'h00F0, 2'd0, 4'd0}   // R8 abort reset
  };

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 ctx", ctx_o, 0); chk("R1 phase", phase_o, 0);
    chk("R1 busy", busy, 0); chk("R1 susp", erase_susp, 0); chk("R1 op_valid", op_valid, 0);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][44]) begin
        rd(VEC[i][43:22]);
        chk($sformatf("R3 rdata vec %0d", i), rdata, VEC[i][21:6]);
      end else wr(VEC[i][43:22], VEC[i][21:6]);
      chk($sformatf("R2 ctx vec %0d", i), ctx_o, VEC[i][5:4]);
      chk($sformatf("R2 phase vec %0d", i), phase_o, VEC[i][3:0]);
    end

    // R3: protection flag low
    prot_in = 1'b0; unlock(8'h90, 0); rd(22'h001002);
    chk("R3 unprotected", rdata, 0); wr(0, 16'h00F0); prot_in = 1'b1;

    // R5 program and busy length
    unlock(8'hA0, 0); chk("R5 phase", phase_o, 3);
    wr(22'h001234, 16'hBEEF);
    chk("R5 valid", op_valid, 1); chk("R5 kind", op_kind, 0);
    chk("R5 addr", op_addr, 22'h001234); chk("R5 data", op_data, 16'hBEEF);
    wr(22'h000555, 16'h00AA);
    chk("R5 write ignored while busy", phase_o, 0);
    count_busy(n); chk("R5 busy cycles", n, BUSY - 1);

    // R6 buffered program, N=4
    unlock(8'h25, 22'h002000); wr(22'h002000, 16'h0003);
    chk("R6 loading phase", phase_o, 5);
    for (int k = 0; k < 4; k++) begin
      wr(22'h002004 + k, 16'h1000 + 16'(k));
      chk("R6 load kind", op_kind, 1); chk("R6 load index", op_count, k);
      chk("R6 load valid", op_valid, 1);
    end
    chk("R6 confirm phase", phase_o, 6);
    wr(22'h002000, 16'h0029);
    chk("R6 bufprog kind", op_kind, 2); chk("R6 bufprog addr", op_addr, 22'h002004);
    chk("R6 bufprog count", op_count, 3); chk("R6 busy", busy, 1);
    wait_idle();

    // R7 page violation
    unlock(8'h25, 0); wr(0, 16'h0001); wr(22'h002004, 16'h1111); wr(22'h002014, 16'h2222);
    chk("R7 page abort", ctx_o, 2);
    unlock(8'hF0, 0); chk("R8 cleared", ctx_o, 0);
    // R7 wrong confirm
    unlock(8'h25, 0); wr(0, 16'h0000); wr(22'h003000, 16'h3333); wr(0, 16'h0028);
    chk("R7 confirm abort", ctx_o, 2);
    unlock(8'hF0, 0);

    // R10 suspend without erase
    wr(0, 16'h00B0); chk("R10 no erase", erase_susp, 0);
    // R11 resume without suspend
    wr(0, 16'h0030); chk("R11 no susp", erase_susp, 0); chk("R11 no op", op_valid, 0);

    // R9 erase
    unlock(8'h80, 0); chk("R9 phase", phase_o, 7);
    unlock(8'h30, 22'h015ABC);
    chk("R9 kind", op_kind, 3); chk("R9 addr", op_addr, 22'h015000); chk("R9 busy", busy, 1);
    wr(0, 16'h00B0);
    chk("R10 susp", erase_susp, 1); chk("R10 busy drops", busy, 0);
    // R12 programs while suspended
    unlock(8'hA0, 0); wr(22'h015F00, 16'h4444);
    chk("R12 same sector ignored", op_valid, 0);
    unlock(8'hA0, 0); wr(22'h027000, 16'h5555);
    chk("R12 other sector", op_valid, 1); chk("R12 other addr", op_addr, 22'h027000);
    wait_idle();
    unlock(8'h90, 0); chk("R12 ident in susp", ctx_o, 1);
    rd(0); chk("R12 ident read", rdata, 16'h00C2);
    wr(0, 16'h00F0);
    chk("R12 back to read", ctx_o, 0); chk("R12 still susp", erase_susp, 1);
    // R11 resume: one erase cycle ran before suspend
    wr(0, 16'h0030);
    chk("R11 resumed", erase_susp, 0);
    count_busy(n); chk("R11 remaining", n, BUSY - 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule